// File: doc/BRIEF.md
# PCI Burst Read Initiator Data-Phase Controller

This block runs the data phases of a zero-wait-state burst memory read, seen from the initiator side of a conventional PCI bus, and hands each returned word to a local master interface. Once the address phase is over (that phase is handled elsewhere), a one-cycle `phase_go` pulse starts the burst. From then on the block drives initiator-ready and samples device-select, target-ready and the 64-bit acknowledge. It captures the bus data into a one-entry holding register at every edge where both ready lines are low.

On the local side, the captured word is offered in the following cycle with a local acknowledge. A transfer strobe, together with low- and high-dword data-valid acknowledges, fires when the local side signalled ready in the cycle before. Three status bits report data-phase mode, 64-bit capability and a completed bus transfer. The local side ends the burst by asserting its "last" request during a completing phase. After that, at most one further phase runs, the block releases initiator-ready, and it returns to idle. All strobes are active low.

Top module: `burst_rd_initiator`

## Requirements
- R1: While `rst_n` is low and after its release, `bus_irdy_n`, `loc_ack_n`, `loc_xfr_n`, `loc_lo_ack_n` and `loc_hi_ack_n` are 1, and `sts_dphase`, `sts_wide` and `sts_xfer` are 0.
- R2: On the first data phase of a burst, `bus_irdy_n` is 0 even when `loc_rdy_n` is 1, provided the holding register is empty.
- R3: On every later data phase, `bus_irdy_n` is 0 only when `loc_rdy_n` is 0 and the holding register is empty or is being emptied in that same cycle.
- R4: A data phase completes at a rising edge where `bus_irdy_n` and `bus_trdy_n` are both 0, and `bus_ad` is then captured into the holding register.
- R5: `sts_dphase` goes to 1 in the same cycle that `bus_devsel_n` is 0 during a burst, and it stays 1 until the burst ends.
- R6: `sts_wide` goes to 1 in the cycle in which the first data phase completes with `bus_ack64_n` at 0. It stays 0 for a burst whose first phase completes with `bus_ack64_n` at 1.
- R7: A captured word appears on `loc_data` in the next cycle with `loc_ack_n` at 0. It stays there, unchanged, until it is transferred.
- R8: `loc_xfr_n` is 0 exactly when `loc_rdy_n` was 0 in the previous cycle and `loc_ack_n` is 0 now. `loc_lo_ack_n` and `loc_hi_ack_n` are 0 in the same cycles.
- R9: `sts_xfer` is 1 in the cycle after each completed data phase.
- R10: If `loc_last_n` is 0 at a completing data phase, the only further phase allowed is the next one to complete. After it, `bus_irdy_n` returns to 1.
- R11: In the cycle after the final data phase, `bus_irdy_n` is 1 and the status bits still show the burst. In the cycle after that, all three status bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| phase_go | input | 1 | One-cycle pulse starting the data phases of a burst |
| bus_devsel_n | input | 1 | Target device-select, active low |
| bus_trdy_n | input | 1 | Target ready, active low |
| bus_ack64_n | input | 1 | Target accepts 64-bit transfers, active low |
| bus_ad | input | 64 | Read data from the bus |
| bus_irdy_n | output | 1 | Initiator ready, active low |
| loc_rdy_n | input | 1 | Local side can accept data, active low |
| loc_last_n | input | 1 | Local request to end the burst, active low |
| loc_ack_n | output | 1 | Valid word on `loc_data`, active low |
| loc_xfr_n | output | 1 | Word handed to local side this cycle, active low |
| loc_lo_ack_n | output | 1 | Low dword valid, active low |
| loc_hi_ack_n | output | 1 | High dword valid, active low |
| loc_data | output | 64 | Word offered to the local side |
| sts_dphase | output | 1 | Data-phase mode |
| sts_wide | output | 1 | Target offers 64-bit transfers |
| sts_xfer | output | 1 | A bus data phase completed in the previous cycle |

## Verification
The bench builds the block with its defaults: a 64-bit data path and a holding register that is cleared on reset. With the full width, every captured word carries a distinct pattern in both dwords, so a lost, duplicated or stale word shows on `loc_data`. One burst runs a zero-wait stream with an early "last" request to check the two-phase limit. A second burst uses a 32-bit target and a local side that is not ready at first. That reaches the case where the first phase proceeds regardless of local readiness, and the case where the full holding register stalls initiator-ready for an extra cycle.

// File: rtl/prd_pkg.sv
package prd_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RUN  = 2'd1,
    PH_LAST = 2'd2,
    PH_END  = 2'd3
  } ph_state_e;

  // Initiator may signal ready when the holding slot is free and either
  // this is the opening phase or the local side is ready.
  function automatic logic irdy_permit(input logic first,
                                       input logic loc_ready,
                                       input logic slot_free);
    return slot_free && (first || loc_ready);
  endfunction

  // Local hand-off fires on ready-last-cycle with a word on offer.
  function automatic logic handoff_fire(input logic rdy_prev,
                                        input logic holding);
    return rdy_prev && holding;
  endfunction

  function automatic ph_state_e next_phase(input ph_state_e cur,
                                           input logic go,
                                           input logic done,
                                           input logic last);
    ph_state_e nxt;
    nxt = cur;
    case (cur)
      PH_IDLE: if (go) nxt = PH_RUN;
      PH_RUN:  if (done && last) nxt = PH_LAST;
      PH_LAST: if (done) nxt = PH_END;
      PH_END:  nxt = PH_IDLE;
      default: nxt = PH_IDLE;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/prd_phase_ctrl.sv
module prd_phase_ctrl
  import prd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic devsel_n,
  input  logic trdy_n,
  input  logic ack64_n,
  input  logic last_n,
  input  logic loc_rdy_n,
  input  logic slot_free,
  output logic irdy_n,
  output logic dp_done,
  output logic first_phase,
  output logic sts_dphase,
  output logic sts_wide,
  output logic sts_xfer
);

  ph_state_e state_q, state_d;
  logic      first_q;
  logic      dphase_q;
  logic      wide_q;
  logic      xfer_q;
  logic      in_burst;
  logic      irdy_on;
  logic      wide_now;

  assign in_burst    = (state_q == PH_RUN) || (state_q == PH_LAST);
  assign first_phase = first_q;
  assign irdy_on     = in_burst && irdy_permit(first_q, !loc_rdy_n, slot_free);
  assign dp_done     = irdy_on && !trdy_n;
  assign wide_now    = first_q && dp_done && !ack64_n;
  assign state_d     = next_phase(state_q, go, dp_done, !last_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= PH_IDLE;
      first_q  <= 1'b0;
      dphase_q <= 1'b0;
      wide_q   <= 1'b0;
      xfer_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      xfer_q  <= dp_done;
      if (state_q == PH_IDLE && go) first_q <= 1'b1;
      else if (dp_done)             first_q <= 1'b0;
      if (state_q == PH_END)                dphase_q <= 1'b0;
      else if (in_burst && !devsel_n)       dphase_q <= 1'b1;
      if (state_q == PH_END)                wide_q <= 1'b0;
      else if (wide_now)                    wide_q <= 1'b1;
    end
  end

  assign irdy_n     = !irdy_on;
  assign sts_dphase = dphase_q || (in_burst && !devsel_n);
  assign sts_wide   = wide_q || wide_now;
  assign sts_xfer   = xfer_q;

endmodule

// File: rtl/prd_hold_buf.sv
module prd_hold_buf
  import prd_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter bit CLEAR_DATA = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              loc_rdy_n,
  output logic              slot_free,
  output logic              ack_n,
  output logic              xfr_n,
  output logic              lo_ack_n,
  output logic              hi_ack_n,
  output logic [DATA_W-1:0] data
);

  localparam int HALF_W = DATA_W / 2;

  logic              vld_q;
  logic              rdy_q;
  logic              fire;
  logic [DATA_W-1:0] word_q;

  assign fire      = handoff_fire(rdy_q, vld_q);
  assign slot_free = !vld_q || fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      rdy_q <= 1'b0;
    end else begin
      rdy_q <= !loc_rdy_n;
      if (capture)   vld_q <= 1'b1;
      else if (fire) vld_q <= 1'b0;
    end
  end

  generate
    if (CLEAR_DATA) begin : g_clr
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       word_q <= '0;
        else if (capture) word_q <= bus_data;
      end
    end else begin : g_noclr
      always_ff @(posedge clk) begin
        if (capture) word_q <= bus_data;
      end
    end
  endgenerate

  assign ack_n    = !vld_q;
  assign xfr_n    = !fire;
  assign lo_ack_n = !(fire && (HALF_W > 0));
  assign hi_ack_n = !fire;
  assign data     = word_q;

endmodule

// File: rtl/burst_rd_initiator.sv
module burst_rd_initiator #(
  parameter int DATA_W     = 64,
  parameter bit CLEAR_DATA = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phase_go,
  input  logic              bus_devsel_n,
  input  logic              bus_trdy_n,
  input  logic              bus_ack64_n,
  input  logic [DATA_W-1:0] bus_ad,
  output logic              bus_irdy_n,
  input  logic              loc_rdy_n,
  input  logic              loc_last_n,
  output logic              loc_ack_n,
  output logic              loc_xfr_n,
  output logic              loc_lo_ack_n,
  output logic              loc_hi_ack_n,
  output logic [DATA_W-1:0] loc_data,
  output logic              sts_dphase,
  output logic              sts_wide,
  output logic              sts_xfer
);

  logic dp_done;
  logic slot_free;
  logic first_phase;

  prd_phase_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (phase_go),
    .devsel_n   (bus_devsel_n),
    .trdy_n     (bus_trdy_n),
    .ack64_n    (bus_ack64_n),
    .last_n     (loc_last_n),
    .loc_rdy_n  (loc_rdy_n),
    .slot_free  (slot_free),
    .irdy_n     (bus_irdy_n),
    .dp_done    (dp_done),
    .first_phase(first_phase),
    .sts_dphase (sts_dphase),
    .sts_wide   (sts_wide),
    .sts_xfer   (sts_xfer)
  );

  prd_hold_buf #(
    .DATA_W    (DATA_W),
    .CLEAR_DATA(CLEAR_DATA)
  ) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (dp_done),
    .bus_data (bus_ad),
    .loc_rdy_n(loc_rdy_n),
    .slot_free(slot_free),
    .ack_n    (loc_ack_n),
    .xfr_n    (loc_xfr_n),
    .lo_ack_n (loc_lo_ack_n),
    .hi_ack_n (loc_hi_ack_n),
    .data     (loc_data)
  );

endmodule

// File: rtl/burst_rd_initiator_chk.sv
module burst_rd_initiator_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_irdy_n,
  input logic bus_trdy_n,
  input logic loc_rdy_n,
  input logic loc_last_n,
  input logic loc_ack_n,
  input logic loc_xfr_n,
  input logic sts_xfer,
  input logic first_phase
);

  logic dp;
  assign dp = !bus_irdy_n && !bus_trdy_n;

  AST_XFR_HAS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    !loc_xfr_n |-> !loc_ack_n); // R8

  AST_XFR_AFTER_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    !loc_xfr_n |-> $past(!loc_rdy_n)); // R8

  AST_LATER_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_irdy_n && !first_phase) |-> !loc_rdy_n); // R3

  AST_XFER_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    dp |=> sts_xfer); // R9

  AST_LAST_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (dp && !loc_last_n) ##1 dp |=> bus_irdy_n); // R10

endmodule

bind burst_rd_initiator burst_rd_initiator_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_irdy_n (bus_irdy_n),
  .bus_trdy_n (bus_trdy_n),
  .loc_rdy_n  (loc_rdy_n),
  .loc_last_n (loc_last_n),
  .loc_ack_n  (loc_ack_n),
  .loc_xfr_n  (loc_xfr_n),
  .sts_xfer   (sts_xfer),
  .first_phase(first_phase)
);

// File: tb/burst_rd_initiator_tb.sv
module burst_rd_initiator_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        phase_go = 1'b0;
  logic        bus_devsel_n = 1'b1;
  logic        bus_trdy_n = 1'b1;
  logic        bus_ack64_n = 1'b1;
  logic [63:0] bus_ad = '0;
  logic        bus_irdy_n;
  logic        loc_rdy_n = 1'b1;
  logic        loc_last_n = 1'b1;
  logic        loc_ack_n, loc_xfr_n, loc_lo_ack_n, loc_hi_ack_n;
  logic [63:0] loc_data;
  logic        sts_dphase, sts_wide, sts_xfer;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  burst_rd_initiator u_dut (
    .clk(clk), .rst_n(rst_n), .phase_go(phase_go),
    .bus_devsel_n(bus_devsel_n), .bus_trdy_n(bus_trdy_n),
    .bus_ack64_n(bus_ack64_n), .bus_ad(bus_ad), .bus_irdy_n(bus_irdy_n),
    .loc_rdy_n(loc_rdy_n), .loc_last_n(loc_last_n), .loc_ack_n(loc_ack_n),
    .loc_xfr_n(loc_xfr_n), .loc_lo_ack_n(loc_lo_ack_n),
    .loc_hi_ack_n(loc_hi_ack_n), .loc_data(loc_data),
    .sts_dphase(sts_dphase), .sts_wide(sts_wide), .sts_xfer(sts_xfer)
  );

  function automatic logic [63:0] pat(input int k);
    return {32'hC0DE0000 + 32'(k), 32'h0000BEEF ^ 32'(k * 3)};
  endfunction

  task automatic check(input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // {go, devsel_n, trdy_n, ack64_n, rdy_n, last_n, ad_sel[2:0],
  //  irdy_n, ack_n, xfr_n, dphase, wide, xfer, chk_data, exp_sel[2:0]}
  localparam logic [18:0] VEC [8] = '{
    19'b1_1_1_1_1_1_000_1_1_1_0_0_0_0_000,
    19'b0_0_1_0_1_1_000_0_1_1_1_0_0_0_000,
    19'b0_0_0_0_0_1_000_0_1_1_1_1_0_0_000,
    19'b0_0_0_0_0_1_001_0_0_0_1_1_1_1_000,
    19'b0_0_0_0_0_0_010_0_0_0_1_1_1_1_001,
    19'b0_0_0_0_0_1_011_0_0_0_1_1_1_1_010,
    19'b0_1_1_1_0_1_100_1_0_0_1_1_1_1_011,
    19'b0_1_1_1_1_1_000_1_1_1_0_0_0_0_000
  };

  task automatic drive(input logic go, input logic dv, input logic tr,
                       input logic a64, input logic rd, input logic ls,
                       input logic [63:0] ad);
    phase_go = go; bus_devsel_n = dv; bus_trdy_n = tr; bus_ack64_n = a64;
    loc_rdy_n = rd; loc_last_n = ls; bus_ad = ad;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1 reset state, during and after reset
    repeat (3) @(negedge clk);
    check("R1 irdy_n in reset", bus_irdy_n, 1);
    check("R1 ack_n in reset", loc_ack_n, 1);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R1 strobes idle", {loc_xfr_n, loc_lo_ack_n, loc_hi_ack_n}, 3'b111);
    check("R1 status clear", {sts_dphase, sts_wide, sts_xfer}, 3'b000);

    // Zero-wait burst with early last: R2 R4 R5 R6 R7 R8 R9 R10 R11
    for (int i = 0; i < 8; i++) begin
      logic [18:0] v;
      v = VEC[i];
      @(negedge clk);
      drive(v[18], v[17], v[16], v[15], v[14], v[13], pat(int'(v[12:10])));
      #1;
      check($sformatf("R2/R3/R10 irdy_n v%0d", i), bus_irdy_n, v[9]);
      check($sformatf("R7 ack_n v%0d", i), loc_ack_n, v[8]);
      check($sformatf("R8 xfr_n v%0d", i), loc_xfr_n, v[7]);
      check($sformatf("R8 dword acks v%0d", i),
            {loc_lo_ack_n, loc_hi_ack_n}, {v[7], v[7]});
      check($sformatf("R5 dphase v%0d", i), sts_dphase, v[6]);
      check($sformatf("R6 wide v%0d", i), sts_wide, v[5]);
      check($sformatf("R9/R11 xfer v%0d", i), sts_xfer, v[4]);
      if (v[3]) check($sformatf("R4/R7 data v%0d", i), loc_data,
                      pat(int'(v[2:0])));
    end

    // 32-bit target, local side not ready at the start
    @(negedge clk); drive(1, 1, 1, 1, 1, 1, '0);
    @(negedge clk); drive(0, 0, 0, 1, 1, 1, pat(5)); #1;
    check("R2 first phase ignores local ready", bus_irdy_n, 0);
    check("R6 no wide with 32-bit target", sts_wide, 0);
    @(negedge clk); drive(0, 0, 0, 1, 1, 1, pat(6)); #1;
    check("R3 later phase waits for local ready", bus_irdy_n, 1);
    check("R7 held word offered", {loc_ack_n, loc_data}, {1'b0, pat(5)});
    check("R8 no strobe without prior ready", loc_xfr_n, 1);
    @(negedge clk); drive(0, 0, 0, 1, 0, 1, pat(6)); #1;
    check("R3 full slot stalls irdy", bus_irdy_n, 1);
    check("R7 held word stable", loc_data, pat(5));
    @(negedge clk); drive(0, 0, 0, 1, 0, 0, pat(6)); #1;
    check("R8 strobe after ready", loc_xfr_n, 0);
    check("R8 data at strobe", loc_data, pat(5));
    check("R3 irdy with ready and draining slot", bus_irdy_n, 0);
    @(negedge clk); drive(0, 0, 0, 1, 0, 1, pat(7)); #1;
    check("R10 one more phase after last", bus_irdy_n, 0);
    check("R4 second word captured", loc_data, pat(6));
    @(negedge clk); drive(0, 0, 0, 1, 0, 1, pat(8)); #1;
    check("R10 irdy released after two phases", bus_irdy_n, 1);
    check("R11 status held in end cycle", {sts_dphase, sts_xfer}, 2'b11);
    check("R6 wide stays low", sts_wide, 0);
    @(negedge clk); drive(0, 1, 1, 1, 1, 1, '0); #1;
    check("R11 status cleared", {sts_dphase, sts_wide, sts_xfer}, 3'b000);
    check("R7 last word delivered", loc_ack_n, 1);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule